// File: doc/BRIEF.md
# Segment Register Load Unit

This block performs the work behind writing a segment register. A request carries a 16-bit selector, the kind of segment being loaded (data, code or stack), the current privilege level and two mode bits. With protection enabled and the virtual-8086 bit clear, the unit checks the selector against the limit of the table it names, fetches the 8-byte descriptor through a simple read port, and applies the protection rules for the requested kind in a fixed order. It then either raises one exception pulse (vector plus 16-bit error code) or writes the hidden descriptor cache and pulses done.

When protection is off or the virtual-8086 bit is set, no table is consulted: the selector is stored and the base becomes the selector shifted left by four. A protected-mode code load also raises a one-cycle flush of the instruction prefetch buffer. Gate handling, task switching and the memory path behind the read port belong to other blocks.

Top module: `seg_load_unit`

## Requirements
- R1: Selector bit 2 picks the local table (base `ldt_base_i`) when set and the global table (`gdt_base_i`) when clear; the descriptor is read at table base plus the selector with its low three bits cleared, and `rd_req_o` stays high until `rd_valid_i` is sampled.
- R2: If the selector with its low three bits cleared exceeds the chosen table limit, vector 13 is raised with the selector as error code and no read is issued.
- R3: Stack load (`kind_i`=2): a zero index (bits 15:3) raises vector 13 with code 0 and no read; otherwise, in this order, a system descriptor (bit 44 clear), an executable (bit 43 set) or non-writable (bit 41 clear) type, or selector RPL (bits 1:0) differing from CPL or from DPL (bits 46:45) raises vector 13 with the selector; a clear present bit (47) then raises vector 12 with the selector.
- R4: Code load (`kind_i`=1): a zero index raises vector 13 with code 0; otherwise, in this order, a system descriptor raises 13, a clear present bit raises 11, a non-executable type raises 13, a conforming type (bit 42 set) with DPL above CPL raises 13, and a non-conforming type with RPL below CPL raises 13; all with the selector as code.
- R5: Data load (`kind_i`=0): a zero index completes without a read and loads base 0, limit 0, attributes 0 and flags 0; otherwise a system descriptor or RPL above DPL or CPL above DPL raises 13, and then a clear present bit raises 11, with the selector as code.
- R6: On success the cache takes the selector, base {bits 63:56, 39:32, 31:16}, limit {bits 51:48, 15:0}, attribute byte bits 47:40 on `cache_attr_o`, flag nibble bits 55:52 on `cache_flags_o` and RPL from selector bits 1:0.
- R7: With the granularity bit (55) set, the cached limit is the 20-bit limit shifted left by 12 with the low 12 bits all ones.
- R8: With `prot_en_i` low or `v86_i` high, the unit completes without a read, stores the selector and sets the base to selector times 16, leaving limit and attributes unchanged.
- R9: A code load with `prot_en_i` high and `v86_i` low pulses `prefetch_flush_o` for one cycle right after the request edge, whatever the outcome; no other load pulses it.
- R10: Every accepted request ends in exactly one one-cycle pulse of `done_o` or `exc_o`, in the cycle after the edge that accepts the request (no-read cases) or samples `rd_valid_i`; a request ending in `exc_o` leaves every cache output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load request, taken when idle |
| sel_i | input | 16 | Selector to load |
| kind_i | input | 2 | 0 data, 1 code, 2 stack |
| cpl_i | input | 2 | Current privilege level |
| prot_en_i | input | 1 | Protection enabled |
| v86_i | input | 1 | Virtual-8086 mode |
| gdt_base_i | input | 32 | Global table base |
| gdt_limit_i | input | 16 | Global table limit |
| ldt_base_i | input | 32 | Local table base |
| ldt_limit_i | input | 16 | Local table limit |
| rd_req_o | output | 1 | Descriptor read pending |
| rd_addr_o | output | 32 | Descriptor address |
| rd_valid_i | input | 1 | Descriptor data valid |
| rd_data_i | input | 64 | Descriptor bytes |
| done_o | output | 1 | Load completed |
| exc_o | output | 1 | Load faulted |
| exc_vec_o | output | 8 | Exception vector |
| exc_code_o | output | 16 | Exception error code |
| prefetch_flush_o | output | 1 | Prefetch invalidate pulse |
| cache_sel_o | output | 16 | Cached selector |
| cache_base_o | output | 32 | Cached base |
| cache_limit_o | output | 32 | Cached limit |
| cache_attr_o | output | 8 | Cached attribute byte |
| cache_flags_o | output | 4 | Cached flag nibble |
| cache_rpl_o | output | 2 | Cached requested privilege |

## Verification
Each segment kind is driven with one descriptor that passes and then with descriptors that break exactly one rule, so a wrong check order shows up as the wrong vector (a descriptor both absent and non-executable must give 11 on a code load, and an absent stack descriptor must give 12, not 11). Selectors at and past the table limit in both tables separate the limit fault from a read, and null selectors separate the accepting data path from the faulting stack and code paths. Granular and byte limits, read wait states, and real and virtual-8086 requests tell apart the cache fill, the handshake and the base-only path, while fault cases following a good load show that the cache was left alone.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam logic [1:0] KIND_DATA  = 2'd0;
  localparam logic [1:0] KIND_CODE  = 2'd1;
  localparam logic [1:0] KIND_STACK = 2'd2;

  localparam logic [7:0] VEC_NP = 8'd11;
  localparam logic [7:0] VEC_SS = 8'd12;
  localparam logic [7:0] VEC_GP = 8'd13;

  // descriptor field layout is fixed by the table format
  typedef struct packed {
    logic [7:0]  base_hi;
    logic        gran;
    logic        big;
    logic        lmode;
    logic        avl;
    logic [3:0]  lim_hi;
    logic        present;
    logic [1:0]  dpl;
    logic        non_sys;
    logic [3:0]  typ;
    logic [7:0]  base_mid;
    logic [15:0] base_lo;
    logic [15:0] lim_lo;
  } seg_desc_t;

  typedef struct packed {
    logic        fault;
    logic [7:0]  vec;
    logic [15:0] code;
  } seg_fault_t;
endpackage

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int SEL_W  = 16
) (
  input  logic [SEL_W-1:2]  idx_ti_i,
  input  logic [ADDR_W-1:0] gdt_base_i,
  input  logic [SEL_W-1:0]  gdt_limit_i,
  input  logic [ADDR_W-1:0] ldt_base_i,
  input  logic [SEL_W-1:0]  ldt_limit_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              over_o
);
  logic [SEL_W-1:0] offs;
  logic             use_ldt;

  assign use_ldt = idx_ti_i[2];
  assign offs    = {idx_ti_i[SEL_W-1:3], 3'b000};
  assign over_o  = use_ldt ? (offs > ldt_limit_i) : (offs > gdt_limit_i);
  assign addr_o  = (use_ldt ? ldt_base_i : gdt_base_i) + ADDR_W'(offs);
endmodule

// File: rtl/seg_prot_check.sv
module seg_prot_check
  import seg_pkg::*;
(
  input  logic [1:0]  kind_i,
  input  logic [1:0]  cpl_i,
  input  logic [15:0] sel_i,
  input  seg_desc_t   desc_i,
  output seg_fault_t  fault_o
);
  logic [1:0] rpl;
  assign rpl = sel_i[1:0];

  always_comb begin
    fault_o = '0;
    case (kind_i)
      KIND_STACK: begin
        if (!desc_i.non_sys)                             fault_o = '{1'b1, VEC_GP, sel_i};
        else if (desc_i.typ[3] || !desc_i.typ[1])        fault_o = '{1'b1, VEC_GP, sel_i};
        else if (rpl != cpl_i || rpl != desc_i.dpl)      fault_o = '{1'b1, VEC_GP, sel_i};
        else if (!desc_i.present)                        fault_o = '{1'b1, VEC_SS, sel_i};
      end
      KIND_CODE: begin
        if (!desc_i.non_sys)                             fault_o = '{1'b1, VEC_GP, sel_i};
        else if (!desc_i.present)                        fault_o = '{1'b1, VEC_NP, sel_i};
        else if (!desc_i.typ[3])                         fault_o = '{1'b1, VEC_GP, sel_i};
        else if (desc_i.typ[2]) begin
          if (desc_i.dpl > cpl_i)                        fault_o = '{1'b1, VEC_GP, sel_i};
        end
        else if (rpl < cpl_i)                            fault_o = '{1'b1, VEC_GP, sel_i};
      end
      default: begin
        if (!desc_i.non_sys)                             fault_o = '{1'b1, VEC_GP, sel_i};
        else if (rpl > desc_i.dpl || cpl_i > desc_i.dpl) fault_o = '{1'b1, VEC_GP, sel_i};
        else if (!desc_i.present)                        fault_o = '{1'b1, VEC_NP, sel_i};
      end
    endcase
  end
endmodule

// File: rtl/seg_cache_fmt.sv
module seg_cache_fmt
  import seg_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12
) (
  input  seg_desc_t         desc_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] limit_o
);
  localparam int LIM_W = 20;
  logic [LIM_W-1:0] lim_raw;

  assign lim_raw = {desc_i.lim_hi, desc_i.lim_lo};
  assign base_o  = ADDR_W'({desc_i.base_hi, desc_i.base_mid, desc_i.base_lo});
  assign limit_o = desc_i.gran ? ADDR_W'({lim_raw, {PAGE_SHIFT{1'b1}}})
                               : ADDR_W'(lim_raw);
endmodule

// File: rtl/seg_load_unit.sv
module seg_load_unit
  import seg_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [15:0]       sel_i,
  input  logic [1:0]        kind_i,
  input  logic [1:0]        cpl_i,
  input  logic              prot_en_i,
  input  logic              v86_i,
  input  logic [ADDR_W-1:0] gdt_base_i,
  input  logic [15:0]       gdt_limit_i,
  input  logic [ADDR_W-1:0] ldt_base_i,
  input  logic [15:0]       ldt_limit_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_valid_i,
  input  logic [63:0]       rd_data_i,
  output logic              done_o,
  output logic              exc_o,
  output logic [7:0]        exc_vec_o,
  output logic [15:0]       exc_code_o,
  output logic              prefetch_flush_o,
  output logic [15:0]       cache_sel_o,
  output logic [ADDR_W-1:0] cache_base_o,
  output logic [ADDR_W-1:0] cache_limit_o,
  output logic [7:0]        cache_attr_o,
  output logic [3:0]        cache_flags_o,
  output logic [1:0]        cache_rpl_o
);
  typedef enum logic {S_IDLE, S_READ} state_e;

  state_e            state_q;
  logic [15:0]       sel_q;
  logic [1:0]        kind_q, cpl_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] tbl_addr, fmt_base, fmt_limit;
  logic              over_lim, null_idx, flat_mode;
  seg_desc_t         desc;
  seg_fault_t        chk;

  assign desc      = seg_desc_t'(rd_data_i);
  assign null_idx  = (sel_i[15:3] == '0);
  assign flat_mode = !prot_en_i || v86_i;

  seg_addr_gen #(.ADDR_W(ADDR_W), .SEL_W(16)) u_addr (
    .idx_ti_i   (sel_i[15:2]),
    .gdt_base_i (gdt_base_i),
    .gdt_limit_i(gdt_limit_i),
    .ldt_base_i (ldt_base_i),
    .ldt_limit_i(ldt_limit_i),
    .addr_o     (tbl_addr),
    .over_o     (over_lim)
  );

  seg_prot_check u_chk (
    .kind_i (kind_q),
    .cpl_i  (cpl_q),
    .sel_i  (sel_q),
    .desc_i (desc),
    .fault_o(chk)
  );

  seg_cache_fmt #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) u_fmt (
    .desc_i (desc),
    .base_o (fmt_base),
    .limit_o(fmt_limit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q          <= S_IDLE;
      sel_q            <= '0;
      kind_q           <= KIND_DATA;
      cpl_q            <= '0;
      addr_q           <= '0;
      done_o           <= 1'b0;
      exc_o            <= 1'b0;
      exc_vec_o        <= '0;
      exc_code_o       <= '0;
      prefetch_flush_o <= 1'b0;
      cache_sel_o      <= '0;
      cache_base_o     <= '0;
      cache_limit_o    <= '0;
      cache_attr_o     <= '0;
      cache_flags_o    <= '0;
      cache_rpl_o      <= '0;
    end else begin
      done_o           <= 1'b0;
      exc_o            <= 1'b0;
      prefetch_flush_o <= 1'b0;
      case (state_q)
        S_IDLE: if (start_i) begin
          sel_q  <= sel_i;
          kind_q <= kind_i;
          cpl_q  <= cpl_i;
          if (flat_mode) begin
            cache_sel_o  <= sel_i;
            cache_base_o <= ADDR_W'({sel_i, 4'h0});
            done_o       <= 1'b1;
          end else begin
            prefetch_flush_o <= (kind_i == KIND_CODE);
            if (null_idx) begin
              if (kind_i == KIND_DATA) begin
                cache_sel_o   <= sel_i;
                cache_base_o  <= '0;
                cache_limit_o <= '0;
                cache_attr_o  <= '0;
                cache_flags_o <= '0;
                cache_rpl_o   <= sel_i[1:0];
                done_o        <= 1'b1;
              end else begin
                exc_o      <= 1'b1;
                exc_vec_o  <= VEC_GP;
                exc_code_o <= '0;
              end
            end else if (over_lim) begin
              exc_o      <= 1'b1;
              exc_vec_o  <= VEC_GP;
              exc_code_o <= sel_i;
            end else begin
              addr_q  <= tbl_addr;
              state_q <= S_READ;
            end
          end
        end
        S_READ: if (rd_valid_i) begin
          state_q <= S_IDLE;
          if (chk.fault) begin
            exc_o      <= 1'b1;
            exc_vec_o  <= chk.vec;
            exc_code_o <= chk.code;
          end else begin
            cache_sel_o   <= sel_q;
            cache_base_o  <= fmt_base;
            cache_limit_o <= fmt_limit;
            cache_attr_o  <= {desc.present, desc.dpl, desc.non_sys, desc.typ};
            cache_flags_o <= {desc.gran, desc.big, desc.lmode, desc.avl};
            cache_rpl_o   <= sel_q[1:0];
            done_o        <= 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign rd_req_o  = (state_q == S_READ);
  assign rd_addr_o = addr_q;

  p_one_outcome_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && exc_o));
  p_fault_keeps_cache_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> ($stable(cache_sel_o) && $stable(cache_base_o) && $stable(cache_limit_o)
               && $stable(cache_attr_o)));
  p_read_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> (!done_o && !exc_o));
  p_stack_fault_kind_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_o && exc_vec_o == VEC_SS) |-> (kind_q == KIND_STACK));
  p_np_not_stack_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_o && exc_vec_o == VEC_NP) |-> (kind_q != KIND_STACK));
  p_flush_code_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prefetch_flush_o |-> (kind_q == KIND_CODE));
  p_flush_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prefetch_flush_o |=> !prefetch_flush_o);
endmodule

// File: tb/tb_seg_load_unit.sv
`timescale 1ns/1ps
module tb_seg_load_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] sel_i = '0;
  logic [1:0]  kind_i = '0, cpl_i = '0;
  logic        prot_en_i = 1'b0, v86_i = 1'b0;
  logic [31:0] gdt_base_i = 32'h0000_1000, ldt_base_i = 32'h0000_8000;
  logic [15:0] gdt_limit_i = 16'h00FF, ldt_limit_i = 16'h003F;
  logic        rd_req_o, rd_valid_i = 1'b0;
  logic [31:0] rd_addr_o;
  logic [63:0] rd_data_i = '0;
  logic        done_o, exc_o, prefetch_flush_o;
  logic [7:0]  exc_vec_o, cache_attr_o;
  logic [15:0] exc_code_o, cache_sel_o;
  logic [31:0] cache_base_o, cache_limit_o;
  logic [3:0]  cache_flags_o;
  logic [1:0]  cache_rpl_o;

  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  seg_load_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .sel_i(sel_i), .kind_i(kind_i),
    .cpl_i(cpl_i), .prot_en_i(prot_en_i), .v86_i(v86_i),
    .gdt_base_i(gdt_base_i), .gdt_limit_i(gdt_limit_i),
    .ldt_base_i(ldt_base_i), .ldt_limit_i(ldt_limit_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
    .done_o(done_o), .exc_o(exc_o), .exc_vec_o(exc_vec_o), .exc_code_o(exc_code_o),
    .prefetch_flush_o(prefetch_flush_o), .cache_sel_o(cache_sel_o),
    .cache_base_o(cache_base_o), .cache_limit_o(cache_limit_o), .cache_attr_o(cache_attr_o),
    .cache_flags_o(cache_flags_o), .cache_rpl_o(cache_rpl_o)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [1:0]  kind;
    logic [1:0]  cpl;
    logic [15:0] sel;
    logic [31:0] base;
    logic [19:0] lim;
    logic [7:0]  acc;
    logic        g;
    logic [7:0]  vec;   // 0 = completes
    logic [15:0] code;
    logic [31:0] addr;  // 0 = no read
  } vec_t;

  localparam int N = 23;
  localparam vec_t TBL [N] = '{
    '{4'd6, 2'd0, 2'd0, 16'h0010, 32'h1234_5678, 20'hABCDE, 8'h92, 1'b0, 8'd0,  16'h0000, 32'h1010},
    '{4'd7, 2'd0, 2'd3, 16'h001B, 32'h0040_0000, 20'h00012, 8'hF2, 1'b1, 8'd0,  16'h0000, 32'h1018},
    '{4'd5, 2'd0, 2'd0, 16'h0013, 32'h0000_0000, 20'h00100, 8'h92, 1'b0, 8'd13, 16'h0013, 32'h1010},
    '{4'd5, 2'd0, 2'd2, 16'h0010, 32'h0000_0000, 20'h00100, 8'hB2, 1'b0, 8'd13, 16'h0010, 32'h1010},
    '{4'd5, 2'd0, 2'd0, 16'h0028, 32'h0000_0000, 20'h00100, 8'h12, 1'b0, 8'd11, 16'h0028, 32'h1028},
    '{4'd5, 2'd0, 2'd0, 16'h0030, 32'h0000_0000, 20'h00100, 8'h82, 1'b0, 8'd13, 16'h0030, 32'h1030},
    '{4'd5, 2'd0, 2'd0, 16'h0003, 32'h5555_0000, 20'h00100, 8'h92, 1'b0, 8'd0,  16'h0000, 32'h0000},
    '{4'd7, 2'd2, 2'd1, 16'h0021, 32'h00AB_C000, 20'hFFFFF, 8'hB2, 1'b1, 8'd0,  16'h0000, 32'h1020},
    '{4'd3, 2'd2, 2'd0, 16'h0020, 32'h0000_0000, 20'h00100, 8'h9A, 1'b0, 8'd13, 16'h0020, 32'h1020},
    '{4'd3, 2'd2, 2'd0, 16'h0020, 32'h0000_0000, 20'h00100, 8'h90, 1'b0, 8'd13, 16'h0020, 32'h1020},
    '{4'd3, 2'd2, 2'd1, 16'h0021, 32'h0000_0000, 20'h00100, 8'h92, 1'b0, 8'd13, 16'h0021, 32'h1020},
    '{4'd3, 2'd2, 2'd0, 16'h0023, 32'h0000_0000, 20'h00100, 8'hF2, 1'b0, 8'd13, 16'h0023, 32'h1020},
    '{4'd3, 2'd2, 2'd0, 16'h0020, 32'h0000_0000, 20'h00100, 8'h12, 1'b0, 8'd12, 16'h0020, 32'h1020},
    '{4'd3, 2'd2, 2'd0, 16'h0000, 32'h0000_0000, 20'h00100, 8'h92, 1'b0, 8'd13, 16'h0000, 32'h0000},
    '{4'd4, 2'd1, 2'd0, 16'h0008, 32'h0001_0000, 20'h0FFFF, 8'h9A, 1'b0, 8'd0,  16'h0000, 32'h1008},
    '{4'd4, 2'd1, 2'd0, 16'h0008, 32'h0000_0000, 20'h00100, 8'h92, 1'b0, 8'd13, 16'h0008, 32'h1008},
    '{4'd4, 2'd1, 2'd0, 16'h0008, 32'h0000_0000, 20'h00100, 8'h12, 1'b0, 8'd11, 16'h0008, 32'h1008},
    '{4'd4, 2'd1, 2'd0, 16'h0008, 32'h0000_0000, 20'h00100, 8'hFE, 1'b0, 8'd13, 16'h0008, 32'h1008},
    '{4'd4, 2'd1, 2'd3, 16'h000B, 32'h0002_0000, 20'h00FFF, 8'h9E, 1'b0, 8'd0,  16'h0000, 32'h1008},
    '{4'd4, 2'd1, 2'd3, 16'h0008, 32'h0000_0000, 20'h00100, 8'h9A, 1'b0, 8'd13, 16'h0008, 32'h1008},
    '{4'd2, 2'd0, 2'd0, 16'h0100, 32'h0000_0000, 20'h00100, 8'h92, 1'b0, 8'd13, 16'h0100, 32'h0000},
    '{4'd1, 2'd0, 2'd0, 16'h0034, 32'h0300_0000, 20'h00200, 8'h92, 1'b0, 8'd0,  16'h0000, 32'h8030},
    '{4'd2, 2'd0, 2'd0, 16'h0044, 32'h0000_0000, 20'h00100, 8'h92, 1'b0, 8'd13, 16'h0044, 32'h0000}
  };

  logic        got_done, got_exc, seen_rd, flush_seen;
  logic [7:0]  got_vec;
  logic [15:0] got_code;
  logic [31:0] got_addr;

  function automatic string tag(input logic [3:0] n);
    case (n)
      4'd1: return "R1";  4'd2: return "R2";  4'd3: return "R3";
      4'd4: return "R4";  4'd5: return "R5";  4'd6: return "R6";
      4'd7: return "R7";  4'd8: return "R8";  4'd9: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input bit ok, input string t, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", t, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] k, input logic [1:0] c, input logic p, input logic v,
                     input logic [15:0] s, input int wn);
    int cnt;
    @(negedge clk);
    kind_i = k; cpl_i = c; prot_en_i = p; v86_i = v; sel_i = s; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    got_done = 0; got_exc = 0; seen_rd = 0; got_vec = '0; got_code = '0; got_addr = '0;
    flush_seen = prefetch_flush_o;
    cnt = 0;
    for (int n = 0; n < 60; n++) begin
      if (done_o || exc_o) begin
        got_done = done_o; got_exc = exc_o; got_vec = exc_vec_o; got_code = exc_code_o;
        break;
      end
      if (rd_req_o) begin
        seen_rd = 1; got_addr = rd_addr_o;
        rd_valid_i = (cnt >= wn);
        cnt++;
      end
      @(negedge clk);
    end
    rd_valid_i = 1'b0;
  endtask

  function automatic logic [63:0] mk(input vec_t t);
    return {t.base[31:24], t.g, 3'b000, t.lim[19:16], t.acc, t.base[23:16], t.base[15:0], t.lim[15:0]};
  endfunction

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL R10: watchdog expired act=hung exp=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] pb, pl, exp_lim;
    logic [15:0] ps;
    logic [7:0]  pa;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk(!done_o && !exc_o && !rd_req_o && !prefetch_flush_o, "R10", {done_o, exc_o, rd_req_o}, 0);
    chk(cache_base_o == 0 && cache_limit_o == 0 && cache_sel_o == 0, "R6", cache_base_o, 0);

    for (int i = 0; i < N; i++) begin
      vec_t t;
      t = TBL[i];
      pb = cache_base_o; pl = cache_limit_o; ps = cache_sel_o; pa = cache_attr_o;
      rd_data_i = mk(t);
      run(t.kind, t.cpl, 1'b1, 1'b0, t.sel, i % 3);
      chk(got_done == (t.vec == 0) && got_exc == (t.vec != 0), tag(t.req), {got_done, got_exc}, t.vec);
      chk(seen_rd == (t.addr != 0), "R1", seen_rd, t.addr != 0);
      if (t.addr != 0) chk(got_addr == t.addr, "R1", got_addr, t.addr);
      chk(flush_seen == (t.kind == 2'd1), "R9", flush_seen, t.kind == 2'd1);
      if (t.vec != 0) begin
        chk(got_vec == t.vec && got_code == t.code, tag(t.req), {got_vec, got_code}, {t.vec, t.code});
        chk(cache_base_o == pb && cache_limit_o == pl && cache_sel_o == ps && cache_attr_o == pa,
            "R10", {cache_sel_o, cache_base_o}, {ps, pb});
      end else if (t.addr == 0) begin
        // null data selector loads an empty cache
        chk(cache_base_o == 0 && cache_limit_o == 0 && cache_attr_o == 0 && cache_flags_o == 0
            && cache_sel_o == t.sel, "R5", {cache_attr_o, cache_base_o}, 0);
      end else begin
        exp_lim = t.g ? {t.lim, 12'hFFF} : {12'h000, t.lim};
        chk(cache_base_o == t.base, "R6", cache_base_o, t.base);
        chk(cache_limit_o == exp_lim, t.g ? "R7" : "R6", cache_limit_o, exp_lim);
        chk(cache_sel_o == t.sel && cache_rpl_o == t.sel[1:0], "R6", cache_sel_o, t.sel);
        chk(cache_attr_o == t.acc && cache_flags_o == {t.g, 3'b000}, "R6",
            {cache_attr_o, cache_flags_o}, {t.acc, t.g, 3'b000});
      end
    end

    // one-cycle pulse
    rd_data_i = mk(TBL[0]);
    run(2'd0, 2'd0, 1'b1, 1'b0, 16'h0010, 4);
    chk(got_done, "R10", got_done, 1);
    @(negedge clk);
    chk(!done_o && !exc_o, "R10", {done_o, exc_o}, 0);

    // real mode: base only
    pl = cache_limit_o; pa = cache_attr_o;
    run(2'd0, 2'd0, 1'b0, 1'b0, 16'h1234, 0);
    chk(got_done && !seen_rd && cache_base_o == 32'h0001_2340 && cache_sel_o == 16'h1234,
        "R8", cache_base_o, 32'h0001_2340);
    chk(cache_limit_o == pl && cache_attr_o == pa, "R8", cache_limit_o, pl);

    // virtual-8086 code load: base only, no flush
    run(2'd1, 2'd3, 1'b1, 1'b1, 16'hF000, 0);
    chk(got_done && !seen_rd && cache_base_o == 32'h000F_0000, "R8", cache_base_o, 32'h000F_0000);
    chk(!flush_seen, "R9", flush_seen, 0);

    // faulting protected code load still flushes
    run(2'd1, 2'd0, 1'b1, 1'b0, 16'h0000, 0);
    chk(flush_seen && got_exc && got_vec == 8'd13 && got_code == 16'h0000, "R9",
        {flush_seen, got_vec}, {1'b1, 8'd13});

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule